// File: doc/BRIEF.md
# Width-Limited In-Order Retire Controller

This block decides, every clock cycle, which of the oldest entries in one thread's reorder buffer leave the buffer. The buffer presents a window of its oldest entries, oldest at index 0, each with a small set of status flags. The controller walks the window from the oldest entry and stops at the first entry that cannot go. Squashed entries are dropped without using commit bandwidth. Executed entries retire up to a fixed width per cycle. Unexecuted serialising operations and unexecuted loads are sent back for execution with their sequence number. A faulting entry starts a trap.

The retire mask and the execution request are combinational, so the buffer can pop and mark entries at the same edge. The architectural PC, next PC, next-next PC, micro-PC and next micro-PC are held in registers and advance once for each committed entry. The per-cycle commit count, a full-width flag and a store-committed flag are registered. A thread state machine has two states, RUN and TRAP_WAIT. Accepting a fault moves RUN to TRAP_WAIT. A separate timer state machine, with states T_IDLE and T_COUNT, counts the trap delay. When it expires, it pulses the squash request and moves the thread back to RUN.

Top module: `retire_ctrl`

## Requirements
- R1: After reset, pc_o=RESET_PC, npc_o=RESET_PC+INSN_BYTES, nnpc_o=RESET_PC+2*INSN_BYTES, upc_o=0 and nupc_o=1. commit_cnt_o, width_full_o, store_done_o, trap_pending_o and trap_squash_o are all 0.
- R2: Entries are examined from index 0 upward (bit i of every vector is entry i). The walk stops at the first entry whose valid or ready bit is 0, and no later entry is retired.
- R3: At most WIDTH executed, non-faulting entries commit in one cycle. commit_cnt_o shows that number in the cycle after. width_full_o is 1 in that cycle exactly when the number equals WIDTH.
- R4: A squashed entry reached by the walk gets its retire_o bit set, does not count toward WIDTH or commit_cnt_o, and lets the walk continue.
- R5: An unexecuted entry with the serialising flag raises nsreq_valid_o, with nsreq_seq_o equal to its sequence number and nsreq_uncached_o=0. This happens only when no entry has committed earlier in the same cycle and stores_pending is 0. The entry is never retired, and the walk stops at it in every case.
- R6: An unexecuted entry with the load flag and without the serialising flag follows the R5 rule, with nsreq_uncached_o=1.
- R7: An executed entry with the fault flag raises trap_take_o and enters TRAP_WAIT, but only under the R5 slot and store conditions. It is never retired, and the walk stops at it.
- R8: trap_squash_o is 1 for exactly one cycle, starting TRAP_LAT clock edges after the edge that accepted the fault. trap_pending_o falls at that same edge. While trap_pending_o is 1, retire_o stays 0.
- R9: Each commit shifts PC<-NPC, NPC<-NNPC, NNPC<-NNPC+INSN_BYTES, uPC<-nUPC, nUPC<-nUPC+1. This is applied as many times as there were commits in that cycle.
- R10: store_done_o is 1 in the cycle after a cycle in which an entry with the store flag committed, and 0 otherwise.
- R11: An unexecuted entry with neither the serialising flag nor the load flag stalls the walk, and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | WIN | Entry present |
| ent_ready | input | WIN | Entry ready to retire |
| ent_squashed | input | WIN | Entry already squashed |
| ent_executed | input | WIN | Entry has executed |
| ent_serial | input | WIN | Serialising, store-conditional or barrier |
| ent_load | input | WIN | Entry is a load |
| ent_store | input | WIN | Entry is a store |
| ent_fault | input | WIN | Entry carries a fault |
| ent_seq | input | WIN*SEQW | Sequence numbers, entry i at bits [i*SEQW +: SEQW] |
| stores_pending | input | 1 | Stores still awaiting writeback |
| retire_o | output | WIN | Entries leaving the buffer this cycle |
| nsreq_valid_o | output | 1 | Execute-at-head request |
| nsreq_seq_o | output | SEQW | Sequence number for the request |
| nsreq_uncached_o | output | 1 | Request is an uncached load |
| trap_take_o | output | 1 | Fault accepted this cycle |
| trap_pending_o | output | 1 | Thread in TRAP_WAIT |
| trap_squash_o | output | 1 | Trap squash pulse |
| pc_o | output | PCW | Architectural PC |
| npc_o | output | PCW | Next PC |
| nnpc_o | output | PCW | Next-next PC |
| upc_o | output | UPCW | Micro-PC |
| nupc_o | output | UPCW | Next micro-PC |
| commit_cnt_o | output | $clog2(WIDTH+1) | Commits in the previous cycle |
| width_full_o | output | 1 | Previous cycle used the full width |
| store_done_o | output | 1 | A store committed in the previous cycle |

## Verification
The walk is tried with windows that are fully ready, short windows, windows with a not-ready gap, and windows with squashed entries ahead of executed ones. These separate stopping on readiness from stopping on width, and show that squashed entries are free. Serialising entries, unexecuted loads and faults are placed at the first slot and behind a commit, with and without pending stores. This separates the slot-0 rule from the store rule and the cached request from the uncached one. A directed trap sequence counts the edges to the squash pulse and shows that nothing retires while the trap is pending. A running model of the PC registers is compared after every cycle.

// File: rtl/retire_pkg.sv
package retire_pkg;
    typedef enum logic {
        TH_RUN,
        TH_TRAP_WAIT
    } th_state_e;

    typedef enum logic {
        T_IDLE,
        T_COUNT
    } tm_state_e;
endpackage

// File: rtl/retire_scan.sv
module retire_scan #(
    parameter int WIDTH = 4,
    parameter int WIN   = 6,
    parameter int SEQW  = 16,
    localparam int CNTW = $clog2(WIDTH + 1)
) (
    input  logic                run_ok,
    input  logic                stores_pending,
    input  logic [WIN-1:0]      ent_valid,
    input  logic [WIN-1:0]      ent_ready,
    input  logic [WIN-1:0]      ent_squashed,
    input  logic [WIN-1:0]      ent_executed,
    input  logic [WIN-1:0]      ent_serial,
    input  logic [WIN-1:0]      ent_load,
    input  logic [WIN-1:0]      ent_store,
    input  logic [WIN-1:0]      ent_fault,
    input  logic [WIN*SEQW-1:0] ent_seq,
    output logic [WIN-1:0]      retire_mask,
    output logic [CNTW-1:0]     commit_count,
    output logic                ns_valid,
    output logic [SEQW-1:0]     ns_seq,
    output logic                ns_uncached,
    output logic                trap_take,
    output logic                store_commit
);
    logic            go  [WIN+1];
    logic [CNTW-1:0] cnt [WIN+1];
    logic [WIN-1:0]  ns_hit;
    logic [WIN-1:0]  unc_hit;
    logic [WIN-1:0]  trap_hit;
    logic [WIN-1:0]  st_hit;

    assign go[0]  = run_ok;
    assign cnt[0] = '0;

    for (genvar g = 0; g < WIN; g++) begin : g_slot
        logic act;
        logic slot0_ok;
        logic is_sq;
        logic is_com;

        assign act      = go[g] && (cnt[g] < CNTW'(WIDTH)) && ent_valid[g] && ent_ready[g];
        assign slot0_ok = (cnt[g] == '0) && !stores_pending;
        assign is_sq    = act && ent_squashed[g];
        assign is_com   = act && !ent_squashed[g] && ent_executed[g] && !ent_fault[g];

        assign ns_hit[g]   = act && !ent_squashed[g] && !ent_executed[g]
                             && (ent_serial[g] || ent_load[g]) && slot0_ok;
        assign unc_hit[g]  = ns_hit[g] && !ent_serial[g];
        assign trap_hit[g] = act && !ent_squashed[g] && ent_executed[g]
                             && ent_fault[g] && slot0_ok;
        assign st_hit[g]   = is_com && ent_store[g];

        assign retire_mask[g] = is_sq || is_com;
        assign go[g+1]        = is_sq || is_com;
        assign cnt[g+1]       = cnt[g] + (is_com ? CNTW'(1) : CNTW'(0));
    end

    assign commit_count = cnt[WIN];
    assign ns_valid     = |ns_hit;
    assign ns_uncached  = |unc_hit;
    assign trap_take    = |trap_hit;
    assign store_commit = |st_hit;

    always_comb begin
        ns_seq = '0;
        for (int i = 0; i < WIN; i++) begin
            if (ns_hit[i]) begin
                ns_seq = ns_seq | ent_seq[i*SEQW +: SEQW];
            end
        end
    end
endmodule

// File: rtl/pc_tracker.sv
module pc_tracker #(
    parameter int          WIDTH      = 4,
    parameter int          PCW        = 32,
    parameter int          UPCW       = 8,
    parameter int          INSN_BYTES = 4,
    parameter logic [31:0] RESET_PC   = 32'h0000_1000,
    localparam int         CNTW       = $clog2(WIDTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CNTW-1:0] k_i,
    output logic [PCW-1:0]  pc_q,
    output logic [PCW-1:0]  npc_q,
    output logic [PCW-1:0]  nnpc_q,
    output logic [UPCW-1:0] upc_q,
    output logic [UPCW-1:0] nupc_q
);
    localparam logic [PCW-1:0] STEP = PCW'(INSN_BYTES);
    localparam logic [PCW-1:0] PC0  = PCW'(RESET_PC);

    logic [PCW-1:0]  pc_d, npc_d, nnpc_d;
    logic [UPCW-1:0] upc_d, nupc_d;

    always_comb begin
        pc_d   = pc_q;
        npc_d  = npc_q;
        nnpc_d = nnpc_q;
        upc_d  = upc_q;
        nupc_d = nupc_q;
        for (int j = 0; j < WIDTH; j++) begin
            if (CNTW'(j) < k_i) begin
                pc_d   = npc_d;
                npc_d  = nnpc_d;
                nnpc_d = nnpc_d + STEP;
                upc_d  = nupc_d;
                nupc_d = nupc_d + UPCW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= PC0;
            npc_q  <= PC0 + STEP;
            nnpc_q <= PC0 + STEP + STEP;
            upc_q  <= '0;
            nupc_q <= UPCW'(1);
        end else begin
            pc_q   <= pc_d;
            npc_q  <= npc_d;
            nnpc_q <= nnpc_d;
            upc_q  <= upc_d;
            nupc_q <= nupc_d;
        end
    end

    // R9
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (k_i == CNTW'(1)) |=> (pc_q == $past(npc_q)) && (upc_q == $past(nupc_q)));
endmodule

// File: rtl/trap_timer.sv
module trap_timer #(
    parameter int  LAT = 3,
    localparam int LW  = (LAT > 1) ? $clog2(LAT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expire_o,
    output logic squash_q
);
    import retire_pkg::*;

    tm_state_e tm_state, tm_next;
    logic [LW-1:0] left_q;

    always_comb begin
        tm_next = tm_state;
        unique case (tm_state)
            T_IDLE:  if (start_i) tm_next = T_COUNT;
            T_COUNT: if (left_q == '0) tm_next = T_IDLE;
            default: tm_next = T_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tm_state <= T_IDLE;
        else        tm_state <= tm_next;
    end

    assign expire_o = (tm_state == T_COUNT) && (left_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q   <= '0;
            squash_q <= 1'b0;
        end else begin
            squash_q <= expire_o;
            if (tm_state == T_IDLE && start_i) left_q <= LW'(LAT - 1);
            else if (tm_state == T_COUNT && left_q != '0) left_q <= left_q - LW'(1);
        end
    end

    // R8
    squash_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_q |=> !squash_q);
endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl #(
    parameter int          WIDTH      = 4,
    parameter int          WIN        = 6,
    parameter int          SEQW       = 16,
    parameter int          PCW        = 32,
    parameter int          UPCW       = 8,
    parameter int          INSN_BYTES = 4,
    parameter int          TRAP_LAT   = 3,
    parameter logic [31:0] RESET_PC   = 32'h0000_1000,
    localparam int         CNTW       = $clog2(WIDTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WIN-1:0]      ent_valid,
    input  logic [WIN-1:0]      ent_ready,
    input  logic [WIN-1:0]      ent_squashed,
    input  logic [WIN-1:0]      ent_executed,
    input  logic [WIN-1:0]      ent_serial,
    input  logic [WIN-1:0]      ent_load,
    input  logic [WIN-1:0]      ent_store,
    input  logic [WIN-1:0]      ent_fault,
    input  logic [WIN*SEQW-1:0] ent_seq,
    input  logic                stores_pending,
    output logic [WIN-1:0]      retire_o,
    output logic                nsreq_valid_o,
    output logic [SEQW-1:0]     nsreq_seq_o,
    output logic                nsreq_uncached_o,
    output logic                trap_take_o,
    output logic                trap_pending_o,
    output logic                trap_squash_o,
    output logic [PCW-1:0]      pc_o,
    output logic [PCW-1:0]      npc_o,
    output logic [PCW-1:0]      nnpc_o,
    output logic [UPCW-1:0]     upc_o,
    output logic [UPCW-1:0]     nupc_o,
    output logic [CNTW-1:0]     commit_cnt_o,
    output logic                width_full_o,
    output logic                store_done_o
);
    import retire_pkg::*;

    th_state_e th_state, th_next;
    logic            run_ok;
    logic [CNTW-1:0] scan_count;
    logic            scan_store;
    logic            expire;

    assign run_ok = (th_state == TH_RUN);

    retire_scan #(.WIDTH(WIDTH), .WIN(WIN), .SEQW(SEQW)) u_scan (
        .run_ok         (run_ok),
        .stores_pending (stores_pending),
        .ent_valid      (ent_valid),
        .ent_ready      (ent_ready),
        .ent_squashed   (ent_squashed),
        .ent_executed   (ent_executed),
        .ent_serial     (ent_serial),
        .ent_load       (ent_load),
        .ent_store      (ent_store),
        .ent_fault      (ent_fault),
        .ent_seq        (ent_seq),
        .retire_mask    (retire_o),
        .commit_count   (scan_count),
        .ns_valid       (nsreq_valid_o),
        .ns_seq         (nsreq_seq_o),
        .ns_uncached    (nsreq_uncached_o),
        .trap_take      (trap_take_o),
        .store_commit   (scan_store)
    );

    pc_tracker #(.WIDTH(WIDTH), .PCW(PCW), .UPCW(UPCW),
                 .INSN_BYTES(INSN_BYTES), .RESET_PC(RESET_PC)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .k_i    (scan_count),
        .pc_q   (pc_o),
        .npc_q  (npc_o),
        .nnpc_q (nnpc_o),
        .upc_q  (upc_o),
        .nupc_q (nupc_o)
    );

    trap_timer #(.LAT(TRAP_LAT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (trap_take_o),
        .expire_o (expire),
        .squash_q (trap_squash_o)
    );

    always_comb begin
        th_next = th_state;
        unique case (th_state)
            TH_RUN:       if (trap_take_o) th_next = TH_TRAP_WAIT;
            TH_TRAP_WAIT: if (expire)      th_next = TH_RUN;
            default:      th_next = TH_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) th_state <= TH_RUN;
        else        th_state <= th_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_cnt_o <= '0;
            width_full_o <= 1'b0;
            store_done_o <= 1'b0;
        end else begin
            commit_cnt_o <= scan_count;
            width_full_o <= (scan_count == CNTW'(WIDTH));
            store_done_o <= scan_store;
        end
    end

    assign trap_pending_o = (th_state == TH_TRAP_WAIT);

    // R8
    hold_in_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pending_o |-> (retire_o == '0));

    // R5
    ns_store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nsreq_valid_o |-> (!stores_pending && !trap_take_o));

    // R7
    trap_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take_o |=> trap_pending_o);
endmodule

// File: tb/tb_retire_ctrl.sv
module tb_retire_ctrl;
    localparam int WIDTH = 4;
    localparam int WIN   = 6;
    localparam int SEQW  = 16;
    localparam int LAT   = 3;
    localparam logic [31:0] PC0 = 32'h0000_1000;

    typedef struct packed {
        logic [5:0] v, r, sq, ex, sr, ld, st, ft;
        logic       sp;
        logic [5:0] eret;
        logic       ens, eunc;
        logic [2:0] eidx, ecnt;
        logic       est;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{6'h3F,6'h3F,6'h00,6'h3F,6'h00,6'h00,6'h00,6'h00,1'b0, 6'h0F,1'b0,1'b0,3'd0,3'd4,1'b0},
        '{6'h07,6'h07,6'h00,6'h07,6'h00,6'h00,6'h00,6'h00,1'b0, 6'h07,1'b0,1'b0,3'd0,3'd3,1'b0},
        '{6'h3F,6'h3B,6'h00,6'h3F,6'h00,6'h00,6'h00,6'h00,1'b0, 6'h03,1'b0,1'b0,3'd0,3'd2,1'b0},
        '{6'h3F,6'h3F,6'h03,6'h3F,6'h00,6'h00,6'h00,6'h00,1'b0, 6'h3F,1'b0,1'b0,3'd0,3'd4,1'b0},
        '{6'h3F,6'h3F,6'h00,6'h3E,6'h01,6'h00,6'h00,6'h00,1'b0, 6'h00,1'b1,1'b0,3'd0,3'd0,1'b0},
        '{6'h3F,6'h3F,6'h00,6'h3D,6'h02,6'h00,6'h00,6'h00,1'b0, 6'h01,1'b0,1'b0,3'd0,3'd1,1'b0},
        '{6'h3F,6'h3F,6'h01,6'h3C,6'h02,6'h00,6'h00,6'h00,1'b0, 6'h01,1'b1,1'b0,3'd1,3'd0,1'b0},
        '{6'h3F,6'h3F,6'h00,6'h3E,6'h01,6'h00,6'h00,6'h00,1'b1, 6'h00,1'b0,1'b0,3'd0,3'd0,1'b0},
        '{6'h3F,6'h3F,6'h00,6'h3E,6'h00,6'h01,6'h00,6'h00,1'b0, 6'h00,1'b1,1'b1,3'd0,3'd0,1'b0},
        '{6'h3F,6'h3F,6'h00,6'h3F,6'h00,6'h00,6'h00,6'h02,1'b0, 6'h01,1'b0,1'b0,3'd0,3'd1,1'b0},
        '{6'h3F,6'h3F,6'h00,6'h3B,6'h00,6'h00,6'h00,6'h00,1'b0, 6'h03,1'b0,1'b0,3'd0,3'd2,1'b0},
        '{6'h01,6'h01,6'h00,6'h01,6'h00,6'h00,6'h01,6'h00,1'b0, 6'h01,1'b0,1'b0,3'd0,3'd1,1'b1},
        '{6'h3F,6'h3F,6'h00,6'h3F,6'h00,6'h00,6'h10,6'h01,1'b1, 6'h00,1'b0,1'b0,3'd0,3'd0,1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [WIN-1:0] ent_valid, ent_ready, ent_squashed, ent_executed;
    logic [WIN-1:0] ent_serial, ent_load, ent_store, ent_fault;
    logic [WIN*SEQW-1:0] ent_seq;
    logic stores_pending;
    logic [WIN-1:0] retire_o;
    logic nsreq_valid_o, nsreq_uncached_o, trap_take_o, trap_pending_o, trap_squash_o;
    logic [SEQW-1:0] nsreq_seq_o;
    logic [31:0] pc_o, npc_o, nnpc_o;
    logic [7:0] upc_o, nupc_o;
    logic [2:0] commit_cnt_o;
    logic width_full_o, store_done_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [31:0] m_pc, m_npc, m_nnpc;
    logic [7:0]  m_upc, m_nupc;

    always #5 clk = ~clk;

    retire_ctrl #(.WIDTH(WIDTH), .WIN(WIN), .SEQW(SEQW), .TRAP_LAT(LAT),
                  .RESET_PC(PC0)) dut (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_squashed(ent_squashed),
        .ent_executed(ent_executed), .ent_serial(ent_serial), .ent_load(ent_load),
        .ent_store(ent_store), .ent_fault(ent_fault), .ent_seq(ent_seq),
        .stores_pending(stores_pending),
        .retire_o(retire_o), .nsreq_valid_o(nsreq_valid_o), .nsreq_seq_o(nsreq_seq_o),
        .nsreq_uncached_o(nsreq_uncached_o), .trap_take_o(trap_take_o),
        .trap_pending_o(trap_pending_o), .trap_squash_o(trap_squash_o),
        .pc_o(pc_o), .npc_o(npc_o), .nnpc_o(nnpc_o), .upc_o(upc_o), .nupc_o(nupc_o),
        .commit_cnt_o(commit_cnt_o), .width_full_o(width_full_o),
        .store_done_o(store_done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t x);
        ent_valid = x.v; ent_ready = x.r; ent_squashed = x.sq; ent_executed = x.ex;
        ent_serial = x.sr; ent_load = x.ld; ent_store = x.st; ent_fault = x.ft;
        stores_pending = x.sp;
    endtask

    task automatic model_advance(input int n);
        for (int j = 0; j < n; j++) begin
            m_pc = m_npc; m_npc = m_nnpc; m_nnpc = m_nnpc + 32'd4;
            m_upc = m_nupc; m_nupc = m_nupc + 8'd1;
        end
    endtask

    task automatic chk_pc(input string tag);
        chk(pc_o == m_pc && npc_o == m_npc && nnpc_o == m_nnpc, "R9", {tag, " pc"},
            {pc_o, npc_o}, {m_pc, m_npc});
        chk(upc_o == m_upc && nupc_o == m_nupc && nnpc_o == m_nnpc, "R9", {tag, " upc"},
            {upc_o, nupc_o}, {m_upc, m_nupc});
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 5000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        vec_t idle_v;
        vec_t run_v;
        vec_t flt_v;
        idle_v = '0;
        run_v = '0;
        run_v.v = 6'h3F; run_v.r = 6'h3F; run_v.ex = 6'h3F;
        flt_v = run_v;
        flt_v.ft = 6'h01;
        for (int i = 0; i < WIN; i++) ent_seq[i*SEQW +: SEQW] = SEQW'(100 + i);
        drive(idle_v);
        m_pc = PC0; m_npc = PC0 + 32'd4; m_nnpc = PC0 + 32'd8; m_upc = 8'd0; m_nupc = 8'd1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        chk_pc("reset");
        chk(commit_cnt_o == 0 && !width_full_o && !store_done_o, "R1", "counters",
            {commit_cnt_o, width_full_o, store_done_o}, 0);
        chk(!trap_pending_o && !trap_squash_o, "R1", "trap state",
            {trap_pending_o, trap_squash_o}, 0);

        // table walk: R2 R3 R4 R5 R6 R7 R9 R10 R11
        for (int n = 0; n < NV; n++) begin
            string tag;
            tag = $sformatf("row%0d", n);
            @(negedge clk);
            drive(VEC[n]);
            #1;
            chk(retire_o == VEC[n].eret, "R2/R4", {tag, " retire"}, retire_o, VEC[n].eret);
            chk(nsreq_valid_o == VEC[n].ens, "R5/R6", {tag, " nsreq"}, nsreq_valid_o, VEC[n].ens);
            if (VEC[n].ens) begin
                chk(nsreq_seq_o == SEQW'(100 + int'(VEC[n].eidx)), "R5", {tag, " seq"},
                    nsreq_seq_o, 100 + int'(VEC[n].eidx));
                chk(nsreq_uncached_o == VEC[n].eunc, "R6", {tag, " uncached"},
                    nsreq_uncached_o, VEC[n].eunc);
            end
            chk(!trap_take_o, "R7", {tag, " no trap"}, trap_take_o, 0);
            @(posedge clk);
            #1;
            model_advance(int'(VEC[n].ecnt));
            chk(commit_cnt_o == VEC[n].ecnt, "R3", {tag, " count"}, commit_cnt_o, VEC[n].ecnt);
            chk(width_full_o == (VEC[n].ecnt == 3'd4), "R3", {tag, " full"},
                width_full_o, VEC[n].ecnt == 3'd4);
            chk(store_done_o == VEC[n].est, "R10", {tag, " store"}, store_done_o, VEC[n].est);
            chk_pc(tag);
        end

        // R10 flag clears when no store commits
        @(negedge clk);
        drive(idle_v);
        @(posedge clk); #1;
        chk(store_done_o == 1'b0, "R10", "store clears", store_done_o, 0);

        // R7 fault accepted at slot 0
        @(negedge clk);
        drive(flt_v);
        #1;
        chk(trap_take_o == 1'b1, "R7", "trap take", trap_take_o, 1);
        chk(retire_o == 0, "R7", "fault not retired", retire_o, 0);
        @(posedge clk); #1;
        chk(trap_pending_o == 1'b1, "R7", "pending set", trap_pending_o, 1);
        chk(commit_cnt_o == 0, "R7", "no commit", commit_cnt_o, 0);

        // R8 timing and hold
        for (int e = 1; e <= LAT; e++) begin
            @(negedge clk);
            drive(run_v);
            ent_squashed = 6'h01;
            #1;
            chk(retire_o == 0, "R8", $sformatf("hold e%0d", e), retire_o, 0);
            chk(!trap_take_o, "R8", $sformatf("no retake e%0d", e), trap_take_o, 0);
            @(posedge clk); #1;
            chk(trap_squash_o == (e == LAT), "R8", $sformatf("squash e%0d", e),
                trap_squash_o, e == LAT);
            chk(trap_pending_o == (e != LAT), "R8", $sformatf("pending e%0d", e),
                trap_pending_o, e != LAT);
        end
        chk_pc("trap");
        @(negedge clk);
        drive(run_v);
        #1;
        chk(retire_o == 6'h0F, "R8", "resume retire", retire_o, 6'h0F);
        @(posedge clk); #1;
        model_advance(4);
        chk(trap_squash_o == 1'b0, "R8", "squash one cycle", trap_squash_o, 0);
        chk_pc("resume");

        // R11 plain unexecuted entry at slot 0 stalls without request
        @(negedge clk);
        drive(run_v);
        ent_executed = 6'h3E;
        #1;
        chk(retire_o == 0 && !nsreq_valid_o, "R11", "plain stall",
            {retire_o, nsreq_valid_o}, 0);
        @(posedge clk); #1;
        chk_pc("stall");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule